// File: doc/BRIEF.md
# E1 Sa6 Code Pattern Detector

This block watches the Sa6 spare bit of an aligned E1 receive stream. Each Sa6 bit arrives with a one-cycle bit strobe. The block packs four successive bits into a nibble, first bit most significant, and sorts the nibble into one of five defined codes or into a catch-all undefined class. A class counts as accepted only once it has appeared in three successive nibbles. An accepted class sets its bit in a sticky status register, which clears when read. When the accepted class differs from the one accepted before it, the block raises a one-cycle change interrupt.

A mode input selects how nibbles are framed. In synchronous mode a submultiframe-start strobe restarts the nibble, so that each nibble covers the four service words of one submultiframe. In this mode updates also require multiframe alignment. In asynchronous mode nibbles run freely, the start strobe is ignored, and so is the multiframe alignment flag. While the receiver reports basic-frame asynchronous state, no update and no interrupt can happen.

Top module: `sa6_code_watch`

## Requirements
- R1: After reset, `statusOut` is all zero, `changeIrq` is low and the nibble assembly is empty.
- R2: A bit is taken only in a cycle with `bitValid` high. Four taken bits form a nibble, first bit most significant. Cycles with `bitValid` low change neither the nibble nor the outputs.
- R3: The nibble 1000 maps to status bit 0, 1010 to bit 1, 1100 to bit 2, 1110 to bit 3 and 1111 to bit 4. Every other value maps to bit 5 (undefined class).
- R4: A class is accepted on the third successive nibble of that class and on every further nibble of the same class. Any nibble of a different class restarts the run at one.
- R5: An accepted nibble with updates enabled sets its status bit. The bit is visible in the cycle after the edge that takes the fourth bit, and it stays set until a read.
- R6: A `readStrobe` cycle clears `statusOut` at the next edge. If a set happens at the same edge, the newly set bit survives the clear.
- R7: `changeIrq` pulses high for one cycle when an accepted class, with updates enabled, differs from the last accepted class. After reset no class counts as accepted.
- R8: While `basicAsync` is high at the completing edge, the status, the interrupt and the last accepted class stay unchanged.
- R9: With `syncMode` high, updates need `mfAligned` high. With `syncMode` low, `mfAligned` has no effect.
- R10: With `syncMode` high, `smfStart` discards any partial nibble, and a bit taken in the same cycle becomes the first bit of a new nibble. With `syncMode` low, `smfStart` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitValid | input | 1 | Strobe: `sa6Bit` holds a new Sa6 bit |
| sa6Bit | input | 1 | Received Sa6 bit value |
| smfStart | input | 1 | Submultiframe-start strobe |
| syncMode | input | 1 | 1: submultiframe-aligned framing, 0: free-running framing |
| basicAsync | input | 1 | Receiver is in basic-frame asynchronous state |
| mfAligned | input | 1 | Multiframe alignment is held |
| readStrobe | input | 1 | Status read; clears the status register |
| statusOut | output | 6 | Sticky one-hot status bits (codes 0..4, undefined class 5) |
| changeIrq | output | 1 | One-cycle pulse on a change of the accepted class |

## Verification
A bit counter that slips by one position, or a shift register that is not emptied on restart, puts the wrong class on `statusOut` at the very next completed nibble. In synchronous mode the same faults also show as an acceptance that arrives one nibble too early or too late. A persistence counter that does not restart, or that fails to saturate, sets a status bit early on the second nibble or misses the fourth nibble after a read. A stale last-accepted register shows up as a missing or spurious `changeIrq` pulse in the cycle right after the completing edge.

// File: rtl/sa6_pkg.sv
package sa6_pkg;

  // Strobes from the framing control to the code datapath
  typedef struct packed {
    logic shiftEn;     // take sa6Bit this cycle
    logic restart;     // drop partial nibble (sync mode start strobe)
    logic nibbleDone;  // this bit completes a nibble
    logic updateEn;    // status and interrupt may change
  } sa6Strobes_t;

  // Value of defined code idx: top bit set plus even steps, last code all ones
  function automatic int codeValue(input int idx, input int width, input int count);
    if (idx == count - 1) return (1 << width) - 1;
    return (1 << (width - 1)) | (idx << 1);
  endfunction

endpackage

// File: rtl/sa6_frame_ctrl.sv
module sa6_frame_ctrl #(
  parameter int NIB_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitValid,
  input  logic                smfStart,
  input  logic                syncMode,
  input  logic                basicAsync,
  input  logic                mfAligned,
  output sa6_pkg::sa6Strobes_t strobes
);
  localparam int CNT_W = (NIB_W > 2) ? $clog2(NIB_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NIB_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic restart;

  assign restart = syncMode & smfStart;

  always_comb begin
    strobes.shiftEn    = bitValid;
    strobes.restart    = restart;
    strobes.nibbleDone = bitValid && !restart && (bitCnt == LAST);
    strobes.updateEn   = !basicAsync && (!syncMode || mfAligned);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (restart) begin
      bitCnt <= bitValid ? CNT_W'(1) : '0;
    end else if (bitValid) begin
      bitCnt <= (bitCnt == LAST) ? '0 : bitCnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/sa6_code_dp.sv
module sa6_code_dp #(
  parameter int NIB_W   = 4,
  parameter int PERSIST = 3,
  parameter int CODES   = 5,
  localparam int STAT_W = CODES + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sa6_pkg::sa6Strobes_t strobes,
  input  logic                 sa6Bit,
  input  logic                 readStrobe,
  output logic [STAT_W-1:0]    statusOut,
  output logic                 changeIrq
);
  localparam int RUN_W = $clog2(PERSIST + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(PERSIST);

  logic [NIB_W-2:0]  shiftReg;
  logic [NIB_W-1:0]  nibble;
  logic [CODES-1:0]  hit;
  logic [STAT_W-1:0] classHot;
  logic [STAT_W-1:0] prevHot;
  logic [STAT_W-1:0] acceptedHot;
  logic [RUN_W-1:0]  runCnt;
  logic [RUN_W-1:0]  nextRun;
  logic              accepted;
  logic              commit;

  assign nibble = {shiftReg, sa6Bit};

  // Classifier: one comparator per defined code, undefined class on top
  for (genvar i = 0; i < CODES; i++) begin : g_code
    assign hit[i] = (nibble == NIB_W'(sa6_pkg::codeValue(i, NIB_W, CODES)));
  end
  assign classHot = {~|hit, hit};

  always_comb begin
    if (classHot != prevHot)  nextRun = RUN_W'(1);
    else if (runCnt == RUN_MAX) nextRun = RUN_MAX;
    else                      nextRun = runCnt + RUN_W'(1);
    accepted = strobes.nibbleDone && (nextRun == RUN_MAX);
    commit   = accepted && strobes.updateEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.restart) begin
      shiftReg <= strobes.shiftEn ? (NIB_W-1)'(sa6Bit) : '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= nibble[NIB_W-2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevHot <= '0;
      runCnt  <= '0;
    end else if (strobes.nibbleDone) begin
      prevHot <= classHot;
      runCnt  <= nextRun;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusOut   <= '0;
      acceptedHot <= '0;
      changeIrq   <= 1'b0;
    end else begin
      statusOut <= (readStrobe ? '0 : statusOut) | (commit ? classHot : '0);
      changeIrq <= commit && (classHot != acceptedHot);
      if (commit) acceptedHot <= classHot;
    end
  end

endmodule

// File: rtl/sa6_code_watch.sv
module sa6_code_watch #(
  parameter int NIB_W   = 4,
  parameter int PERSIST = 3,
  parameter int CODES   = 5,
  localparam int STAT_W = CODES + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitValid,
  input  logic              sa6Bit,
  input  logic              smfStart,
  input  logic              syncMode,
  input  logic              basicAsync,
  input  logic              mfAligned,
  input  logic              readStrobe,
  output logic [STAT_W-1:0] statusOut,
  output logic              changeIrq
);
  sa6_pkg::sa6Strobes_t strobes;

  sa6_frame_ctrl #(.NIB_W(NIB_W)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bitValid   (bitValid),
    .smfStart   (smfStart),
    .syncMode   (syncMode),
    .basicAsync (basicAsync),
    .mfAligned  (mfAligned),
    .strobes    (strobes)
  );

  sa6_code_dp #(.NIB_W(NIB_W), .PERSIST(PERSIST), .CODES(CODES)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sa6Bit     (sa6Bit),
    .readStrobe (readStrobe),
    .statusOut  (statusOut),
    .changeIrq  (changeIrq)
  );

endmodule

// File: rtl/sa6_code_watch_chk.sv
module sa6_code_watch_chk #(
  parameter int STAT_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitValid,
  input logic              syncMode,
  input logic              basicAsync,
  input logic              mfAligned,
  input logic              readStrobe,
  input logic [STAT_W-1:0] statusOut,
  input logic              changeIrq
);
  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readStrobe |=> ((statusOut & $past(statusOut)) == $past(statusOut)));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !bitValid) |=> (statusOut == '0));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!bitValid && !readStrobe) |=> ($stable(statusOut) && !changeIrq));

  // R7
  irq_has_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    changeIrq |-> (statusOut != '0));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    changeIrq |=> !changeIrq);

  // R8
  basic_async_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (basicAsync && !readStrobe) |=> ($stable(statusOut) && !changeIrq));

  // R9
  sync_needs_mf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && !mfAligned) |=> !changeIrq);

endmodule

bind sa6_code_watch sa6_code_watch_chk #(.STAT_W(CODES + 1)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitValid   (bitValid),
  .syncMode   (syncMode),
  .basicAsync (basicAsync),
  .mfAligned  (mfAligned),
  .readStrobe (readStrobe),
  .statusOut  (statusOut),
  .changeIrq  (changeIrq)
);

// File: tb/test_sa6_code_watch.sv
module test_sa6_code_watch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, bitValid, sa6Bit, smfStart, syncMode, basicAsync, mfAligned, readStrobe;
  logic [5:0] statusOut;
  logic changeIrq;

  int checks = 0;
  int errors = 0;

  // model state
  int mCnt, mSh, mPrev, mRun, mAcc;
  logic [5:0] expStat;
  logic expIrq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa6_code_watch i_sa6_code_watch (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .sa6Bit(sa6Bit),
    .smfStart(smfStart), .syncMode(syncMode), .basicAsync(basicAsync),
    .mfAligned(mfAligned), .readStrobe(readStrobe),
    .statusOut(statusOut), .changeIrq(changeIrq)
  );

  function automatic int classOf(input int v);
    case (v)
      8:  return 0;
      10: return 1;
      12: return 2;
      14: return 3;
      15: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if (statusOut !== expStat || changeIrq !== expIrq) begin
      errors++;
      $display("FAIL %s status=%b irq=%b expected status=%b irq=%b",
               tag, statusOut, changeIrq, expStat, expIrq);
    end
  endtask

  // one cycle of stimulus with model update and a check after the edge
  task automatic step(input bit valid, input bit b, input bit smf, input bit rd, input string tag);
    logic [5:0] nextStat;
    bit done;
    int c;
    @(negedge clk);
    bitValid = valid; sa6Bit = b; smfStart = smf; readStrobe = rd;
    done = 0;
    expIrq = 1'b0;
    if (syncMode && smf) begin mCnt = 0; mSh = 0; end
    if (valid) begin
      mSh = ((mSh << 1) | int'(b)) & 15;
      mCnt++;
      if (mCnt == 4) begin done = 1; mCnt = 0; end
    end
    nextStat = rd ? 6'd0 : expStat;
    if (done) begin
      c = classOf(mSh);
      if (c == mPrev) mRun = (mRun < 3) ? mRun + 1 : 3;
      else mRun = 1;
      mPrev = c;
      if (mRun == 3 && !basicAsync && (!syncMode || mfAligned)) begin
        nextStat[c] = 1'b1;
        if (c != mAcc) begin expIrq = 1'b1; mAcc = c; end
      end
    end
    expStat = nextStat;
    @(negedge clk);
    bitValid = 0; smfStart = 0; readStrobe = 0;
    check(tag);
    expIrq = 1'b0;
  endtask

  task automatic sendNib(input int v, input string tag);
    for (int i = 3; i >= 0; i--) step(1, v[i], 0, 0, tag);
  endtask

  task automatic readStat(input string tag);
    step(0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; bitValid = 0; sa6Bit = 0; smfStart = 0; readStrobe = 0;
    syncMode = 0; basicAsync = 0; mfAligned = 1;
    mCnt = 0; mSh = 0; mPrev = -1; mRun = 0; mAcc = -1;
    expStat = '0; expIrq = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rstN = 1;
    @(negedge clk);
    check("R1 after release");

    // R3 R4 R5 R7: sweep every nibble value three times, read between values
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 3; k++) sendNib(v, "R3 sweep");
      readStat("R6 read");
    end

    // R4: run restart on a different class
    sendNib(8, "R4"); sendNib(8, "R4"); sendNib(10, "R4");
    sendNib(8, "R4"); sendNib(8, "R4"); sendNib(8, "R4");
    sendNib(8, "R4 saturated");
    readStat("R6");
    sendNib(8, "R5 re-set after read");

    // R2: idle cycles between bits
    for (int k = 0; k < 3; k++)
      for (int i = 3; i >= 0; i--) begin
        step(1, i != 0, 0, 0, "R2 gap");
        step(0, 1, 0, 0, "R2 idle");
        step(0, 0, 0, 0, "R2 idle");
      end

    // R6: read and set at the same edge
    readStat("R6");
    sendNib(12, "R6"); sendNib(12, "R6");
    step(1, 1, 0, 0, "R6"); step(1, 1, 0, 0, "R6"); step(1, 0, 0, 0, "R6");
    step(1, 0, 0, 1, "R6 set wins");
    readStat("R6");

    // R8: basic-frame asynchronous state blocks updates
    basicAsync = 1;
    for (int k = 0; k < 3; k++) sendNib(15, "R8 blocked");
    basicAsync = 0;
    sendNib(15, "R8 released");
    readStat("R6");

    // R9: sync mode needs multiframe alignment, async mode does not
    syncMode = 1; mfAligned = 0;
    for (int k = 0; k < 3; k++) sendNib(14, "R9 sync unaligned");
    mfAligned = 1;
    sendNib(14, "R9 sync aligned");
    syncMode = 0; mfAligned = 0;
    for (int k = 0; k < 3; k++) sendNib(10, "R9 async unaligned");
    mfAligned = 1;
    readStat("R6");

    // R10: sync mode start strobe restarts the nibble
    syncMode = 1;
    for (int k = 0; k < 3; k++) begin
      step(1, 0, 0, 0, "R10 partial"); step(1, 1, 0, 0, "R10 partial");
      step(1, 1, 1, 0, "R10 restart");
      step(1, 0, 0, 0, "R10"); step(1, 0, 0, 0, "R10"); step(1, 0, 0, 0, "R10");
    end
    step(1, 1, 0, 0, "R10 partial");
    step(0, 0, 1, 0, "R10 bare restart");
    sendNib(8, "R10 after bare restart");
    readStat("R6");
    // R10: async mode ignores the strobe
    syncMode = 0;
    for (int k = 0; k < 3; k++) begin
      step(1, 1, 0, 0, "R10 async"); step(1, 1, 0, 0, "R10 async");
      step(1, 1, 1, 0, "R10 async ignored"); step(1, 1, 0, 0, "R10 async");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule